// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A character is offered on an 8-bit data input with a valid/ready handshake. The frame shape comes from a 7-bit configuration input, which is captured when the character is accepted. It sets the character length (5 to 8 bits), whether a parity bit follows the data, how that parity is formed (even, odd or a constant value), and whether the frame ends with one stop bit or a longer stop period.

Timing comes from a one-cycle enable, `baud_tick`, that pulses at sixteen times the bit rate. Every bit lasts sixteen ticks. The half stop bit used by 5-bit characters lasts eight ticks. One configuration bit is not captured. It acts live and pulls the line low while it is set. The frame sequencer keeps running unchanged underneath it, so the frame ends at the same time it would have without the silencing.

The sequencer is a five-state machine:

- `ST_IDLE` goes to `ST_START` when a character is accepted.
- `ST_START` goes to `ST_DATA` after one bit time.
- `ST_DATA` stays in place until the last data bit has finished. It then goes to `ST_PARITY` if parity is enabled, and to `ST_STOP` if it is not.
- `ST_PARITY` goes to `ST_STOP` after one bit time.
- `ST_STOP` goes back to `ST_IDLE` when the stop period runs out.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and between frames, `line_out` is 1 (unless silenced), `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` is 1 and `in_ready` is 0 until the frame ends. The frame opens with a start bit of 0 lasting 16 ticks.
- R3: Data bits follow the start bit least significant bit first, 16 ticks each. `cfg[6:5]` selects the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Data bits above the selected length are not sent.
- R4: When `cfg[1]` is 1, one parity bit lasting 16 ticks is placed between the last data bit and the stop period. When `cfg[1]` is 0, no parity bit is sent.
- R5: With parity enabled and `cfg[3]` at 0, `cfg[2]` = 1 makes the number of ones across the data and parity bits even, and `cfg[2]` = 0 makes it odd.
- R6: With parity enabled and `cfg[3]` at 1, the parity bit is the constant 0 when `cfg[2]` is 1 and the constant 1 when `cfg[2]` is 0.
- R7: The stop period is at level 1. It lasts 16 ticks when `cfg[4]` is 0, 24 ticks when `cfg[4]` is 1 with a 5-bit length, and 32 ticks when `cfg[4]` is 1 with a 6-, 7- or 8-bit length.
- R8: While `cfg[0]` is 1, `line_out` is 0 in the same cycle. Frame timing and `busy` are not affected.
- R9: `cfg[6:1]` is captured at acceptance. Changes to it during a frame have no effect on that frame.
- R10: The frame advances only on cycles with `baud_tick` high. `busy` falls right after the clock edge that consumes the last stop tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| cfg | input | 7 | Frame configuration; bit 0 is the live silence control |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| line_out | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and 16 ticks per bit. The stop period can therefore be 16, 24 or 32 ticks, and all four length codes are legal. The bench drives `baud_tick` once every three cycles. This exercises the rule that the frame holds still between ticks while keeping each frame to a few hundred cycles. With these settings, every combination of length, parity mode and stop period can be reached, and each frame is compared tick by tick against a frame computed independently in the bench.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       long_stop;
        logic       par_const;
        logic       par_even;
        logic       par_en;
    } frame_cfg_t;

    function automatic frame_cfg_t unpack_cfg(input logic [6:1] c);
        frame_cfg_t f;
        f.par_en    = c[1];
        f.par_even  = c[2];
        f.par_const = c[3];
        f.long_stop = c[4];
        f.len_code  = c[6:5];
        return f;
    endfunction

endpackage

// File: rtl/serial_tx_parity.sv
module serial_tx_parity #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic              par_even,
    input  logic              par_const,
    output logic              par_bit
);
    localparam int NB_W = $clog2(DATA_W + 1);

    logic [NB_W-1:0]   nbits;
    logic [DATA_W-1:0] masked;

    assign nbits = NB_W'(MIN_LEN) + NB_W'(len_code);

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (NB_W'(i) < nbits);
    end

    always_comb begin
        if (par_const) begin
            par_bit = ~par_even;
        end else begin
            par_bit = (^masked) ^ ~par_even;
        end
    end
endmodule

// File: rtl/serial_tx_timer.sv
module serial_tx_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = en && tick && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || done) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import serial_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [6:0]        cfg,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              line_out,
    output logic              busy
);
    localparam int MIN_LEN = DATA_W - 3;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int CNT_W   = $clog2(2 * OVERSAMPLE + 1);

    tx_state_t         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    frame_cfg_t        fcfg_q;
    logic              accept, bit_done, par_bit, line_frame;
    logic [CNT_W-1:0]  limit, stop_ticks;
    logic [IDX_W-1:0]  last_idx;

    assign accept   = in_valid && (state_q == ST_IDLE);
    assign last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(fcfg_q.len_code);

    always_comb begin
        if (!fcfg_q.long_stop) begin
            stop_ticks = CNT_W'(OVERSAMPLE);
        end else if (fcfg_q.len_code == 2'b00) begin
            stop_ticks = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2);
        end else begin
            stop_ticks = CNT_W'(2 * OVERSAMPLE);
        end
        limit = (state_q == ST_STOP) ? stop_ticks : CNT_W'(OVERSAMPLE);
    end

    serial_tx_timer #(.CNT_W(CNT_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (state_q != ST_IDLE),
        .tick  (baud_tick),
        .limit (limit),
        .done  (bit_done)
    );

    serial_tx_parity #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) parity_i (
        .data      (data_q),
        .len_code  (fcfg_q.len_code),
        .par_even  (fcfg_q.par_even),
        .par_const (fcfg_q.par_const),
        .par_bit   (par_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_START;
            ST_START:  if (bit_done) state_d = ST_DATA;
            ST_DATA:   if (bit_done && idx_q == last_idx)
                           state_d = fcfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_d = ST_STOP;
            ST_STOP:   if (bit_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
            fcfg_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                idx_q  <= '0;
                data_q <= in_data;
                fcfg_q <= unpack_cfg(cfg[6:1]);
            end else if (state_q == ST_DATA && bit_done) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line_frame = 1'b1;
            ST_START:  line_frame = 1'b0;
            ST_DATA:   line_frame = data_q[idx_q];
            ST_PARITY: line_frame = par_bit;
            ST_STOP:   line_frame = 1'b1;
            default:   line_frame = 1'b1;
        endcase
        line_out = line_frame & ~cfg[0];
        busy     = (state_q != ST_IDLE);
        in_ready = (state_q == ST_IDLE);
    end
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic [6:0] cfg,
    input logic       in_valid,
    input logic       in_ready,
    input logic       line_out,
    input logic       busy
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg[0]) |-> (line_out && in_ready)); // R1

    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready)); // R2

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!line_out || cfg[0])); // R2

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(line_out) || $past(cfg[0]))); // R7

    AST_SILENCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[0] |-> !line_out); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(baud_tick) && $stable(cfg[0])) |-> $stable(line_out)); // R10
endmodule

bind serial_frame_tx serial_frame_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .cfg       (cfg),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .line_out  (line_out),
    .busy      (busy)
);

// File: tb/serial_frame_tx_tb_top.sv
`timescale 1ns/1ps
module serial_frame_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [6:0] cfg = '0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, line_out, busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic got [0:299];

    always #2 clk = ~clk;

    serial_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg(cfg),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .line_out(line_out), .busy(busy)
    );

    // cfg fields: [0] silence, [1] parity on, [2] even, [3] constant parity,
    // [4] long stop, [6:5] length code (00=5 .. 11=8)
    localparam int NVEC = 8;
    localparam logic [14:0] VECS [NVEC] = '{
        {7'h60, 8'hA5},  // R3 8 bits, no parity, 1 stop
        {7'h12, 8'h13},  // R5 R7 5 bits, odd, 1.5 stop
        {7'h36, 8'h2D},  // R5 R7 6 bits, even, 2 stop
        {7'h4E, 8'h7F},  // R6 7 bits, constant 0
        {7'h7A, 8'h00},  // R6 R7 8 bits, constant 1, 2 stop
        {7'h10, 8'h1F},  // R7 5 bits, no parity, 1.5 stop
        {7'h62, 8'hFF},  // R4 R5 8 bits, odd
        {7'h20, 8'hC3}   // R3 6 bits, upper data bits dropped
    };

    function automatic int nbits(input logic [6:0] c);
        return 5 + int'(c[6:5]);
    endfunction

    function automatic int frame_ticks(input logic [6:0] c);
        int st;
        st = !c[4] ? 16 : (c[6:5] == 2'b00 ? 24 : 32);
        return 16 * (1 + nbits(c) + int'(c[1])) + st;
    endfunction

    function automatic logic exp_bit(input logic [6:0] c, input logic [7:0] d, input int t);
        int slot, ones;
        slot = t / 16;
        ones = 0;
        for (int i = 0; i < nbits(c); i++) ones += int'(d[i]);
        if (slot == 0) return 1'b0;
        if (slot <= nbits(c)) return d[slot-1];
        if (c[1] && slot == nbits(c) + 1) begin
            if (c[3]) return ~c[2];
            return c[2] ? logic'(ones % 2) : ~logic'(ones % 2);
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_frame(input logic [6:0] c, input logic [7:0] d, input logic [6:0] c_after,
                             input int mlo, input int mhi, input string tag);
        int n, ph, bad_at;
        logic m, tk;
        @(negedge clk);
        cfg = c; in_data = d; in_valid = 1'b1; baud_tick = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(busy && !in_ready, {tag, " R2 busy/ready after accept"}, int'({busy, in_ready}), 2);
        n = 0; ph = 0;
        while (busy && n < 300) begin
            tk = (ph == 2);
            ph = (ph == 2) ? 0 : ph + 1;
            m = (n >= mlo && n < mhi);
            cfg = {c_after[6:1], m};
            baud_tick = tk;
            #1;
            if (tk) begin
                got[n] = line_out;
                n++;
            end
            @(negedge clk);
        end
        baud_tick = 1'b0;
        cfg[0] = 1'b0;
        check(n == frame_ticks(c), {tag, " R10 R7 frame length in ticks"}, n, frame_ticks(c));
        bad_at = -1;
        for (int t = 0; t < n; t++) begin
            logic e;
            e = (t >= mlo && t < mhi) ? 1'b0 : exp_bit(c, d, t);
            if (got[t] !== e && bad_at < 0) bad_at = t;
        end
        check(bad_at < 0, {tag, " R3 R4 frame waveform, first bad tick"}, bad_at, -1);
        #1;
        check(line_out && in_ready && !busy, {tag, " R1 idle after frame"},
              int'({line_out, in_ready, busy}), 6);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(line_out === 1'b1, "R1 reset line", int'(line_out), 1);
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        check(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_frame(VECS[v][14:8], VECS[v][7:0], VECS[v][14:8], -1, -1, $sformatf("vec%0d", v));
        end

        // R8: silencing while idle
        @(negedge clk);
        cfg = 7'h01;
        #1;
        check(line_out == 1'b0 && busy == 1'b0, "R8 silence while idle", int'({line_out, busy}), 0);
        cfg = 7'h00;

        // R8: silence mid-frame, timing unchanged
        run_frame(7'h36, 8'h5A, 7'h36, 20, 60, "silence_mid");
        // R9: configuration changed after acceptance is ignored
        run_frame(7'h12, 8'h0B, 7'h7A, -1, -1, "cfg_change_R9");
        run_frame(7'h7E, 8'h81, 7'h00, -1, -1, "cfg_change2_R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule